// File: doc/BRIEF.md
# DRAM ECC Error Log Registers

This block sits beside the SECDED checker of a DRAM controller and keeps a software-visible record of the memory errors that checker finds. For each beat that fails the check, the checker presents one event. The event carries a flag that tells a correctable single-bit error from an uncorrectable double-bit error. It also carries the received and recomputed check bytes, the data word, and the chip select, bank, row and column of the access. The block keeps a running total for each error class in a saturating counter. It keeps one snapshot holding the details of the most recent captured error, and it raises cause bits that drive a single interrupt line.

Software reaches the block through a plain 32-bit register port. Reads are combinational from the address. Writes take effect on the next rising clock edge. A typical handler reads the counters and the snapshot, then writes zero to the cause bits and counters it has consumed. Single-bit errors update the snapshot only once their running count reaches a programmable threshold, while double-bit errors always update it. A master enable in the configuration register gates all logging.

Top module: `dram_ecc_log`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: The configuration register at offset 0x00 stores bit 18 (ECC logging enable), bit 17 (registered memory) and bit 15 (1 = 64-bit bus, 0 = 32-bit bus). All its other bits read zero.
- R3: While the enable bit is 0, an error event changes no counter, no snapshot field and no cause bit.
- R4: The single-bit count at 0x58 and the double-bit count at 0x5C each increase by one for each enabled event of their class, and they stop at all-ones instead of wrapping.
- R5: Writing zero to a counter clears it. Writing any non-zero value to a counter leaves it unchanged.
- R6: The cause registers at 0xD0 and 0xD8 both set bit 0 on a single-bit event and bit 1 on a double-bit event. Writing 0 to a cause bit clears it, and writing 1 leaves it unchanged.
- R7: `irq` is high exactly when any bit of either cause register is set.
- R8: Every enabled double-bit event is captured. The snapshot has five fields. At 0x50, bit 0 holds the type (1 = double) and bits 2:1 the chip select, with the column in bits 22:8 and the bank in bits 25:23. At 0x4C, the row sits in bits 23:8 and the computed check byte in bits 7:0. At 0x48, the received check byte sits in bits 7:0. At 0x40 and 0x44 are the upper and lower 32 bits of the data word.
- R9: A single-bit event is captured, with type bit 0, only when the threshold in bits 23:16 of 0x54 is non-zero and the single-bit count after that event is at or above the threshold. The threshold reads back from the same field.
- R10: Each capture overwrites the whole snapshot, so only the latest captured error is visible.
- R11: When an event and a software write of zero to the counter or cause register it affects land in the same cycle, the event wins. The counter increases from its old value, and the cause bit stays set.
- R12: Writes to the snapshot registers (0x40 through 0x50) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | One failing beat reported this cycle |
| ev_dbl | input | 1 | 1 = uncorrectable double-bit, 0 = corrected single-bit |
| ev_rx_chk | input | 8 | Check byte read from memory |
| ev_calc_chk | input | 8 | Check byte recomputed from the data |
| ev_data | input | DATA_W | Data word of the failing beat |
| ev_cs | input | 2 | Chip select of the access |
| ev_bank | input | 3 | Bank of the access |
| ev_row | input | 16 | Row of the access |
| ev_col | input | 15 | Column of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | OR of all cause bits |

## Verification
An event or a write presented before a rising edge changes the counters, snapshot and cause bits at that edge. A combinational read of the new value, and the new `irq` level, are valid for the whole following cycle. The driver applies each stimulus for exactly one cycle, starting on a falling edge. It queues the expected read value, and the monitor compares it one nanosecond after the next rising edge. No sample therefore falls on an edge, and every sample sees exactly the edge that applied the stimulus. The same-cycle collision cases present the event and the clearing write on the same falling edge, so both reach the same rising edge.

// File: rtl/dram_ecc_log_pkg.sv
// Package: register offsets, field positions and the capture record type
// shared by the error log block, its submodules and its checker.
package dram_ecc_log_pkg;

    localparam int REG_W  = 32;
    localparam int CHK_W  = 8;
    localparam int CS_W   = 2;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 15;
    localparam int THR_W  = 8;

    // Byte offsets decoded by software
    localparam logic [8:0] OFF_CFG    = 9'h000;
    localparam logic [8:0] OFF_DHI    = 9'h040;
    localparam logic [8:0] OFF_DLO    = 9'h044;
    localparam logic [8:0] OFF_RXCHK  = 9'h048;
    localparam logic [8:0] OFF_CALC   = 9'h04C;
    localparam logic [8:0] OFF_LOC    = 9'h050;
    localparam logic [8:0] OFF_CTRL   = 9'h054;
    localparam logic [8:0] OFF_SBECNT = 9'h058;
    localparam logic [8:0] OFF_DBECNT = 9'h05C;
    localparam logic [8:0] OFF_CAUSEA = 9'h0D0;
    localparam logic [8:0] OFF_CAUSEB = 9'h0D8;

    // Configuration bits
    localparam int CFG_EN_BIT   = 18;
    localparam int CFG_REGD_BIT = 17;
    localparam int CFG_WIDE_BIT = 15;

    // Field positions
    localparam int THR_LSB  = 16;
    localparam int TYPE_BIT = 0;
    localparam int CS_LSB   = 1;
    localparam int COL_LSB  = 8;
    localparam int BANK_LSB = 23;
    localparam int ROW_LSB  = 8;

    // Cause vector
    localparam int CAUSE_N   = 2;
    localparam int CAUSE_SBE = 0;
    localparam int CAUSE_DBE = 1;

    // Class index used by the counter array
    localparam int CLS_N   = 2;
    localparam int CLS_SBE = 0;
    localparam int CLS_DBE = 1;

    typedef struct packed {
        logic              dbl;
        logic [CS_W-1:0]   cs;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [CHK_W-1:0]  rx;
        logic [CHK_W-1:0]  calc;
    } err_rec_t;

endpackage

// File: rtl/ecc_sat_counter.sv
// Saturating event counter.
// Counts one per cycle with inc high and holds at all-ones.
// A clear request is honoured only in a cycle without inc, so an event is
// never lost to a clear.
module ecc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count, saturate, or clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            if (cnt != {W{1'b1}}) begin
                cnt <= cnt + W'(1);
            end
        end else if (clr) begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/ecc_cause_bits.sv
// Cause bit vector.
// A software write clears each bit written as 0 and keeps each bit written
// as 1. A set request in the same cycle overrides the clear.
module ecc_cause_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         wr,
    input  logic [N-1:0] keep,
    output logic [N-1:0] bits
);

    // Merge hardware sets with software write-zero clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            bits <= set | (wr ? (bits & keep) : bits);
        end
    end

endmodule

// File: rtl/ecc_capture.sv
// Snapshot of the latest captured error.
// Every load overwrites all fields. There is no software write path.
module ecc_capture
    import dram_ecc_log_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  err_rec_t          rec_in,
    input  logic [DATA_W-1:0] data_in,
    output err_rec_t          rec_q,
    output logic [DATA_W-1:0] data_q
);

    // Overwrite the whole record on each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            rec_q  <= rec_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/dram_ecc_log.sv
// DRAM ECC error log register block (top).
// It takes per-beat error events from an external SECDED checker. It counts
// single-bit and double-bit errors separately, latches the latest captured
// error and raises cause bits and irq.
// Assumes at most one event per cycle, DATA_W > 32 and CNT_W <= 32.
// Reads are combinational and writes take effect at the next rising edge.
module dram_ecc_log
    import dram_ecc_log_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_dbl,
    input  logic [7:0]        ev_rx_chk,
    input  logic [7:0]        ev_calc_chk,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [1:0]        ev_cs,
    input  logic [2:0]        ev_bank,
    input  logic [15:0]       ev_row,
    input  logic [14:0]       ev_col,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int HI_W  = DATA_W - REG_W;
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    // Configuration and control state
    logic             cfg_en_q;
    logic             cfg_regd_q;
    logic             cfg_wide_q;
    logic [THR_W-1:0] thr_q;

    // Address decode
    logic hit_cfg, hit_ctrl, hit_causea, hit_causeb;
    logic [CLS_N-1:0] hit_cnt;

    // Event qualification
    logic             sbe_hit, dbe_hit;
    logic [CNT_W-1:0] sbe_after;
    logic             sbe_capture;
    logic             cap_load;

    // Counters, causes and snapshot
    logic [CNT_W-1:0]   cnt_q [CLS_N];
    logic [CLS_N-1:0]   cnt_inc;
    logic [CLS_N-1:0]   cnt_clr;
    logic [CNT_W-1:0]   sbe_cnt, dbe_cnt;
    logic [CAUSE_N-1:0] cause_set;
    logic [CAUSE_N-1:0] cause_err, cause_msg;
    err_rec_t           ev_rec;
    err_rec_t           cap_q;
    logic [DATA_W-1:0]  cap_data;
    logic               cap_is_dbl;

    // Decode the register offset for writes
    always_comb begin
        hit_cfg          = (reg_addr == ADDR_W'(OFF_CFG));
        hit_ctrl         = (reg_addr == ADDR_W'(OFF_CTRL));
        hit_causea       = (reg_addr == ADDR_W'(OFF_CAUSEA));
        hit_causeb       = (reg_addr == ADDR_W'(OFF_CAUSEB));
        hit_cnt[CLS_SBE] = (reg_addr == ADDR_W'(OFF_SBECNT));
        hit_cnt[CLS_DBE] = (reg_addr == ADDR_W'(OFF_DBECNT));
    end

    // Configuration register: only the three defined bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en_q   <= 1'b0;
            cfg_regd_q <= 1'b0;
            cfg_wide_q <= 1'b0;
        end else if (reg_wr && hit_cfg) begin
            cfg_en_q   <= reg_wdata[CFG_EN_BIT];
            cfg_regd_q <= reg_wdata[CFG_REGD_BIT];
            cfg_wide_q <= reg_wdata[CFG_WIDE_BIT];
        end
    end

    // Error control register: single-bit capture threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (reg_wr && hit_ctrl) begin
            thr_q <= reg_wdata[THR_LSB +: THR_W];
        end
    end

    // Qualify the incoming event with the enable bit
    always_comb begin
        sbe_hit   = cfg_en_q && ev_valid && !ev_dbl;
        dbe_hit   = cfg_en_q && ev_valid &&  ev_dbl;
        sbe_after = (sbe_cnt == {CNT_W{1'b1}}) ? sbe_cnt : sbe_cnt + CNT_W'(1);
        sbe_capture = sbe_hit && (thr_q != '0) &&
                      (CMP_W'(sbe_after) >= CMP_W'(thr_q));
        cap_load  = dbe_hit || sbe_capture;
    end

    assign cnt_inc[CLS_SBE] = sbe_hit;
    assign cnt_inc[CLS_DBE] = dbe_hit;

    // One saturating counter per error class
    for (genvar g = 0; g < CLS_N; g++) begin : g_cnt
        assign cnt_clr[g] = reg_wr && hit_cnt[g] && (reg_wdata == '0);
        ecc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .clr   (cnt_clr[g]),
            .cnt   (cnt_q[g])
        );
    end

    assign sbe_cnt = cnt_q[CLS_SBE];
    assign dbe_cnt = cnt_q[CLS_DBE];

    assign cause_set[CAUSE_SBE] = sbe_hit;
    assign cause_set[CAUSE_DBE] = dbe_hit;

    // Error cause register
    ecc_cause_bits #(.N(CAUSE_N)) u_cause_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cause_set),
        .wr    (reg_wr && hit_causea),
        .keep  (reg_wdata[CAUSE_N-1:0]),
        .bits  (cause_err)
    );

    // Message cause register
    ecc_cause_bits #(.N(CAUSE_N)) u_cause_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cause_set),
        .wr    (reg_wr && hit_causeb),
        .keep  (reg_wdata[CAUSE_N-1:0]),
        .bits  (cause_msg)
    );

    // Pack the event fields into a capture record
    always_comb begin
        ev_rec.dbl  = ev_dbl;
        ev_rec.cs   = ev_cs;
        ev_rec.bank = ev_bank;
        ev_rec.row  = ev_row;
        ev_rec.col  = ev_col;
        ev_rec.rx   = ev_rx_chk;
        ev_rec.calc = ev_calc_chk;
    end

    ecc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cap_load),
        .rec_in  (ev_rec),
        .data_in (ev_data),
        .rec_q   (cap_q),
        .data_q  (cap_data)
    );

    assign cap_is_dbl = cap_q.dbl;

    // Interrupt line: any pending cause
    assign irq = (|cause_err) || (|cause_msg);

    // Combinational read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CFG): begin
                reg_rdata[CFG_EN_BIT]   = cfg_en_q;
                reg_rdata[CFG_REGD_BIT] = cfg_regd_q;
                reg_rdata[CFG_WIDE_BIT] = cfg_wide_q;
            end
            ADDR_W'(OFF_DHI):   reg_rdata[HI_W-1:0] = cap_data[DATA_W-1:REG_W];
            ADDR_W'(OFF_DLO):   reg_rdata = cap_data[REG_W-1:0];
            ADDR_W'(OFF_RXCHK): reg_rdata[CHK_W-1:0] = cap_q.rx;
            ADDR_W'(OFF_CALC): begin
                reg_rdata[CHK_W-1:0]         = cap_q.calc;
                reg_rdata[ROW_LSB +: ROW_W]  = cap_q.row;
            end
            ADDR_W'(OFF_LOC): begin
                reg_rdata[TYPE_BIT]           = cap_q.dbl;
                reg_rdata[CS_LSB +: CS_W]     = cap_q.cs;
                reg_rdata[COL_LSB +: COL_W]   = cap_q.col;
                reg_rdata[BANK_LSB +: BANK_W] = cap_q.bank;
            end
            ADDR_W'(OFF_CTRL):   reg_rdata[THR_LSB +: THR_W] = thr_q;
            ADDR_W'(OFF_SBECNT): reg_rdata = REG_W'(sbe_cnt);
            ADDR_W'(OFF_DBECNT): reg_rdata = REG_W'(dbe_cnt);
            ADDR_W'(OFF_CAUSEA): reg_rdata[CAUSE_N-1:0] = cause_err;
            ADDR_W'(OFF_CAUSEB): reg_rdata[CAUSE_N-1:0] = cause_msg;
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dram_ecc_log_chk.sv
// Checker for dram_ecc_log, attached by bind.
// It watches the enable, counters, causes and snapshot type across cycles.
module dram_ecc_log_chk
    import dram_ecc_log_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ecc_en,
    input logic               ev_valid,
    input logic               ev_dbl,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [CNT_W-1:0]   sbe_cnt,
    input logic [CNT_W-1:0]   dbe_cnt,
    input logic [CAUSE_N-1:0] cause_err,
    input logic [CAUSE_N-1:0] cause_msg,
    input logic               cap_is_dbl,
    input logic               irq
);

    logic wr_sbe;
    assign wr_sbe = reg_wr && (reg_addr == ADDR_W'(OFF_SBECNT));

    // R3: a disabled event with no software write leaves the state alone
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !reg_wr) |=> ($stable(sbe_cnt) && $stable(dbe_cnt) &&
                                  $stable(cause_err) && $stable(cause_msg)));

    // R4: without a write to it, the single-bit count never goes down
    p_cnt_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sbe |=> (sbe_cnt >= $past(sbe_cnt)));

    // R4: a full counter stays full
    p_cnt_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sbe_cnt == {CNT_W{1'b1}}) && !wr_sbe) |=> (sbe_cnt == {CNT_W{1'b1}}));

    // R6: a double-bit event sets bit 1 in both cause registers
    p_dbe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && ev_valid && ev_dbl) |=> (cause_err[CAUSE_DBE] && cause_msg[CAUSE_DBE]));

    // R7: any enabled event raises the interrupt
    p_event_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && ev_valid) |=> irq);

    // R8: a double-bit event is always captured with type 1
    p_dbe_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && ev_valid && ev_dbl) |=> cap_is_dbl);

    // R11: a single-bit event beats a same-cycle clear of its counter
    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && ev_valid && !ev_dbl) |=> (sbe_cnt != '0));

    // R11: a double-bit event beats a same-cycle clear of its counter
    p_dbe_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && ev_valid && ev_dbl) |=> (dbe_cnt != '0));

endmodule

bind dram_ecc_log dram_ecc_log_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_en     (cfg_en_q),
    .ev_valid   (ev_valid),
    .ev_dbl     (ev_dbl),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .sbe_cnt    (sbe_cnt),
    .dbe_cnt    (dbe_cnt),
    .cause_err  (cause_err),
    .cause_msg  (cause_msg),
    .cap_is_dbl (cap_is_dbl),
    .irq        (irq)
);

// File: tb/test_dram_ecc_log.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares them.
module test_dram_ecc_log;

    localparam int DATA_W = 64;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ev_valid, ev_dbl;
    logic [7:0]        ev_rx_chk, ev_calc_chk;
    logic [DATA_W-1:0] ev_data;
    logic [1:0]        ev_cs;
    logic [2:0]        ev_bank;
    logic [15:0]       ev_row;
    logic [14:0]       ev_col;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              irq;

    always #2 clk = ~clk;

    dram_ecc_log #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dram_ecc_log (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dbl(ev_dbl),
        .ev_rx_chk(ev_rx_chk), .ev_calc_chk(ev_calc_chk), .ev_data(ev_data),
        .ev_cs(ev_cs), .ev_bank(ev_bank), .ev_row(ev_row), .ev_col(ev_col),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       exp;
        string             tag;
    } item_t;

    item_t exp_q[$];
    logic  rd_go = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: compare each queued read one ns after the edge it depends on
    always begin : monitor
        item_t it;
        @(posedge clk);
        #1;
        if (rd_go && exp_q.size() > 0) begin
            it = exp_q.pop_front();
            n_chk++;
            if (reg_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: addr 0x%03h actual 0x%08h expected 0x%08h",
                         it.tag, it.addr, reg_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        rd_go    = 1'b1;
        it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        rd_go = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_ev(input logic dbl, input logic [1:0] cs, input logic [2:0] bank,
                          input logic [15:0] row, input logic [14:0] col,
                          input logic [7:0] rx, input logic [7:0] calc,
                          input logic [63:0] data);
        ev_valid = 1'b1; ev_dbl = dbl; ev_cs = cs; ev_bank = bank; ev_row = row;
        ev_col = col; ev_rx_chk = rx; ev_calc_chk = calc; ev_data = data;
    endtask

    task automatic ev(input logic dbl, input logic [1:0] cs, input logic [2:0] bank,
                      input logic [15:0] row, input logic [14:0] col,
                      input logic [7:0] rx, input logic [7:0] calc, input logic [63:0] data);
        @(negedge clk);
        set_ev(dbl, cs, bank, row, col, rx, calc, data);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // Event and register write presented in the same cycle
    task automatic ev_wr(input logic dbl, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        set_ev(dbl, 2'd2, 3'd5, 16'hBEEF, 15'h1234, 8'hA5, 8'h3C, 64'h1122334455667788);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; ev_valid = 1'b0; ev_dbl = 1'b0; ev_rx_chk = '0; ev_calc_chk = '0;
        ev_data = '0; ev_cs = '0; ev_bank = '0; ev_row = '0; ev_col = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(9'h000, 32'h0, "R1 cfg");
        rd(9'h050, 32'h0, "R1 loc");
        rd(9'h054, 32'h0, "R1 ctrl");
        rd(9'h058, 32'h0, "R1 sbe cnt");
        rd(9'h05C, 32'h0, "R1 dbe cnt");
        rd(9'h0D0, 32'h0, "R1 cause err");
        chk_irq(1'b0, "R1 irq");

        // R3: disabled logging ignores events
        ev(1'b1, 2'd1, 3'd1, 16'h1, 15'h1, 8'h1, 8'h2, 64'h1);
        ev(1'b0, 2'd1, 3'd1, 16'h1, 15'h1, 8'h1, 8'h2, 64'h1);
        rd(9'h058, 32'h0, "R3 sbe cnt");
        rd(9'h05C, 32'h0, "R3 dbe cnt");
        rd(9'h050, 32'h0, "R3 loc");
        rd(9'h0D8, 32'h0, "R3 cause msg");

        // R2: configuration bits
        wr(9'h000, 32'hFFFF_FFFF);
        rd(9'h000, 32'h0006_8000, "R2 cfg all ones");
        wr(9'h000, 32'h0004_0000);
        rd(9'h000, 32'h0004_0000, "R2 cfg enable only");

        // R8: double-bit capture with all fields
        ev(1'b1, 2'd2, 3'd5, 16'hBEEF, 15'h1234, 8'hA5, 8'h3C, 64'h1122334455667788);
        rd(9'h050, 32'h0292_3405, "R8 loc");
        rd(9'h04C, 32'h00BE_EF3C, "R8 calc row");
        rd(9'h048, 32'h0000_00A5, "R8 rx");
        rd(9'h040, 32'h1122_3344, "R8 data hi");
        rd(9'h044, 32'h5566_7788, "R8 data lo");
        rd(9'h05C, 32'h1, "R4 dbe cnt");
        rd(9'h0D0, 32'h2, "R6 cause err dbe");
        rd(9'h0D8, 32'h2, "R6 cause msg dbe");
        chk_irq(1'b1, "R7 irq set");

        // R9: threshold 0 never captures single-bit errors
        ev(1'b0, 2'd0, 3'd1, 16'h1, 15'h1, 8'h11, 8'h22, 64'h0);
        rd(9'h058, 32'h1, "R4 sbe cnt");
        rd(9'h050, 32'h0292_3405, "R9 thr0 no capture");
        rd(9'h0D0, 32'h3, "R6 cause err both");

        // R9: threshold 3, capture only from the third error
        wr(9'h054, 32'h0003_0000);
        rd(9'h054, 32'h0003_0000, "R9 thr readback");
        ev(1'b0, 2'd0, 3'd1, 16'h2, 15'h2, 8'h11, 8'h22, 64'h0);
        rd(9'h050, 32'h0292_3405, "R9 below thr");
        ev(1'b0, 2'd1, 3'd3, 16'h0012, 15'h7FFF, 8'h0F, 8'hF0, 64'hDEADBEEF_CAFEF00D);
        rd(9'h050, 32'h01FF_FF02, "R9 at thr loc");
        rd(9'h04C, 32'h0000_12F0, "R10 calc row");
        rd(9'h048, 32'h0000_000F, "R10 rx");
        rd(9'h040, 32'hDEAD_BEEF, "R10 data hi");
        rd(9'h044, 32'hCAFE_F00D, "R10 data lo");
        rd(9'h058, 32'h3, "R4 sbe cnt 3");

        // R6 / R7: write-zero clear of cause bits
        wr(9'h0D0, 32'hFFFF_FFFF);
        rd(9'h0D0, 32'h3, "R6 write ones keeps");
        wr(9'h0D0, 32'hFFFF_FFFE);
        rd(9'h0D0, 32'h2, "R6 clear bit0");
        wr(9'h0D8, 32'h0);
        rd(9'h0D8, 32'h0, "R6 clear msg");
        chk_irq(1'b1, "R7 irq one pending");
        wr(9'h0D0, 32'h0);
        rd(9'h0D0, 32'h0, "R6 clear err");
        chk_irq(1'b0, "R7 irq cleared");

        // R5: counter clear only on zero write
        wr(9'h058, 32'h5);
        rd(9'h058, 32'h3, "R5 nonzero ignored");
        wr(9'h058, 32'h0);
        rd(9'h058, 32'h0, "R5 zero clears");

        // R11: event beats same-cycle clear
        ev_wr(1'b1, 9'h05C, 32'h0);
        rd(9'h05C, 32'h2, "R11 dbe cnt");
        ev_wr(1'b1, 9'h0D0, 32'h0);
        rd(9'h0D0, 32'h2, "R11 cause kept");
        rd(9'h05C, 32'h3, "R11 dbe cnt after");

        // R12: snapshot registers ignore writes
        wr(9'h050, 32'h0);
        rd(9'h050, 32'h0292_3405, "R12 loc write");
        wr(9'h04C, 32'h0);
        rd(9'h04C, 32'h00BE_EF3C, "R12 calc write");

        // R4: saturation of the single-bit counter
        for (int i = 0; i < 260; i++) begin
            ev(1'b0, 2'd3, 3'd7, 16'hFFFF, 15'h0, 8'h66, 8'h55, 64'h0);
        end
        rd(9'h058, 32'h0000_00FF, "R4 saturate");
        rd(9'h050, 32'h0380_0006, "R10 latest sbe loc");
        rd(9'h04C, 32'h00FF_FF55, "R10 latest sbe calc");

        // R3: disable again, event ignored
        wr(9'h000, 32'h0);
        ev(1'b1, 2'd0, 3'd0, 16'h0, 15'h0, 8'h0, 8'h0, 64'h0);
        rd(9'h05C, 32'h3, "R3 disabled dbe cnt");
        rd(9'h050, 32'h0380_0006, "R3 disabled loc");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule